// File: doc/BRIEF.md
# Joinable Transmit/Receive Word FIFO Pair

This block holds the word queues between a host bus and one serial state machine. The transmit queue carries words from the host to the machine. The receive queue carries words from the machine back to the host. There are eight 32-bit words of storage, built as two banks of four. In the default split arrangement each direction owns one bank. Two configuration bits can give all eight words to a single direction. The direction that gives up its storage is then disabled.

The join arrangement is held in a four-state mode register. The states are `JM_SPLIT`, `JM_TXJ`, `JM_RXJ` and `JM_OFF`. Reset enters `JM_SPLIT`. Every configuration write (`cfg_we`) moves the register to the state named by `{cfg_rx_join, cfg_tx_join}`: 00 goes to `JM_SPLIT`, 01 to `JM_TXJ`, 10 to `JM_RXJ` and 11 to `JM_OFF`. The same write empties both queues, even when it does not change the state.

On each side the queue offers a push or pop strobe and the head word. Outputs are visible combinationally. Stall flags tell the machine to retry. Each direction reports a level count, a full flag and an empty flag, all measured against the usable depth of the current state. Host writes that meet a full transmit queue set a sticky overflow flag.

Top module: `sm_fifo_pair`

## Requirements
- R1: After reset the mode is split. Both levels are 0, both empty flags are 1, both full flags are 0 and `tx_overflow` is 0.
- R2: In `JM_SPLIT` each direction holds up to 4 words. Its full flag rises when its level reaches 4.
- R3: In `JM_TXJ` the transmit queue holds up to 8 words. The receive queue has depth 0 and shows `rx_empty`=1, `rx_full`=1 and `rx_level`=0.
- R4: In `JM_RXJ` the receive queue holds up to 8 words. The transmit queue has depth 0 and shows `tx_empty`=1, `tx_full`=1 and `tx_level`=0.
- R5: In `JM_OFF` both directions have depth 0. Both show empty=1, full=1 and level 0.
- R6: A cycle with `cfg_we`=1 leaves both levels at 0 on the next cycle, whatever the old or new mode. Pushes and pops in that same cycle are discarded.
- R7: A host push while `tx_full`=1 is dropped, so the level and contents do not change. It sets `tx_overflow`, which then stays at 1.
- R8: `tx_overflow` is cleared only by a cycle with `ovf_clear`=1 and no overflowing push. If both happen in one cycle, the flag stays set.
- R9: `sm_tx_stall` equals `sm_tx_pop && tx_empty`, and `sm_rx_stall` equals `sm_rx_push && rx_full`. A stalled pop or push, or a host pop of an empty receive queue, leaves the contents and level unchanged.
- R10: Words leave each queue in the order they were accepted. The head word is on `sm_tx_data` or `host_rx_data` whenever that queue is not empty. A pop and a push in the same cycle both take effect when the pre-cycle level allows each one.
- R11: When a direction's depth is non-zero, its full flag is `level == depth` and its empty flag is `level == 0`. The levels are 4 bits wide, so they can show 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe. Applies the join bits and flushes both queues |
| cfg_tx_join | input | 1 | Give all storage to the transmit direction |
| cfg_rx_join | input | 1 | Give all storage to the receive direction |
| host_tx_push | input | 1 | Host writes a word into the transmit queue |
| host_tx_data | input | 32 | Word written by the host |
| host_rx_pop | input | 1 | Host removes the head of the receive queue |
| host_rx_data | output | 32 | Head of the receive queue |
| ovf_clear | input | 1 | Write-one-to-clear strobe for the overflow flag |
| tx_overflow | output | 1 | Sticky flag for a dropped host write |
| sm_tx_pop | input | 1 | Machine removes the head of the transmit queue |
| sm_tx_data | output | 32 | Head of the transmit queue |
| sm_tx_stall | output | 1 | Machine pop refused because the queue is empty |
| sm_rx_push | input | 1 | Machine writes a word into the receive queue |
| sm_rx_data | input | 32 | Word written by the machine |
| sm_rx_stall | output | 1 | Machine push refused because the queue is full |
| tx_level | output | 4 | Words held in the transmit queue |
| rx_level | output | 4 | Words held in the receive queue |
| tx_full | output | 1 | Transmit queue at usable depth, or disabled |
| tx_empty | output | 1 | Transmit queue holds no words |
| rx_full | output | 1 | Receive queue at usable depth, or disabled |
| rx_empty | output | 1 | Receive queue holds no words |

## Verification
The bench targets these corner cases:

- **Fill limit.** It fills each queue to exactly its usable depth in every mode, then pushes once more. A design that computes fullness from the physical eight words would accept a fifth word in split mode. It would also report the disabled direction as merely empty.
- **Same-value configuration write.** It writes the configuration while data is queued, including a write with the unchanged value. A design that flushes only on a real mode change would keep stale words.
- **Overflow against clear.** It pushes into a full queue in the same cycle as the clear strobe. Giving priority to the clear would lose the event.
- **Pointer wrap.** It runs simultaneous push and pop on a full or empty queue under random traffic, and lets the joined pointer wrap across both banks. Wrong wrap masking would return words out of order or from the other bank.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
    typedef enum logic [1:0] {
        JM_SPLIT = 2'd0,
        JM_TXJ   = 2'd1,
        JM_RXJ   = 2'd2,
        JM_OFF   = 2'd3
    } join_mode_e;
endpackage

// File: rtl/fifo_pair_ctrl.sv
module fifo_pair_ctrl
    import fifo_pair_pkg::*;
#(
    parameter int BANK_DEPTH = 4,
    parameter int LVL_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_tx_join,
    input  logic             cfg_rx_join,
    output logic             flush,
    output logic             split,
    output logic [LVL_W-1:0] tx_depth,
    output logic [LVL_W-1:0] rx_depth
);
    localparam logic [LVL_W-1:0] HALF = LVL_W'(BANK_DEPTH);
    localparam logic [LVL_W-1:0] ALL  = LVL_W'(2 * BANK_DEPTH);

    join_mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        if (cfg_we) begin
            unique case ({cfg_rx_join, cfg_tx_join})
                2'b00: mode_d = JM_SPLIT;
                2'b01: mode_d = JM_TXJ;
                2'b10: mode_d = JM_RXJ;
                2'b11: mode_d = JM_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= JM_SPLIT;
        else        mode_q <= mode_d;
    end

    always_comb begin
        flush = cfg_we;
        split = 1'b0;
        unique case (mode_q)
            JM_SPLIT: begin tx_depth = HALF;    rx_depth = HALF;    split = 1'b1; end
            JM_TXJ:   begin tx_depth = ALL;     rx_depth = '0;      end
            JM_RXJ:   begin tx_depth = '0;      rx_depth = ALL;     end
            JM_OFF:   begin tx_depth = '0;      rx_depth = '0;      end
        endcase
    end
endmodule

// File: rtl/fifo_pair_queue.sv
module fifo_pair_queue #(
    parameter int PTR_W = 3,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [LVL_W-1:0] depth,
    input  logic             push,
    input  logic             pop,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [PTR_W-1:0] wrap_mask;

    assign wrap_mask = PTR_W'(depth - LVL_W'(1));
    assign full      = (level >= depth);
    assign empty     = (level == '0);
    assign push_ok   = push && !full && !flush;
    assign pop_ok    = pop && !empty && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr + PTR_W'(1)) & wrap_mask;
            if (pop_ok)  rd_ptr <= (rd_ptr + PTR_W'(1)) & wrap_mask;
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/fifo_pair_store.sv
module fifo_pair_store #(
    parameter int DATA_W     = 32,
    parameter int BANK_DEPTH = 4,
    parameter int PTR_W      = 3
) (
    input  logic              clk,
    input  logic              wa_en,
    input  logic [PTR_W-1:0]  wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [PTR_W-1:0]  wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [PTR_W-1:0]  ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [PTR_W-1:0]  rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    localparam int NUM_BANKS = 2;
    localparam int BANK_AW   = PTR_W - 1;

    logic [DATA_W-1:0] bank_ra [NUM_BANKS];
    logic [DATA_W-1:0] bank_rb [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] words [BANK_DEPTH];
        logic sel_a, sel_b;

        assign sel_a = wa_en && (wa_addr[PTR_W-1] == 1'(b));
        assign sel_b = wb_en && (wb_addr[PTR_W-1] == 1'(b));

        always_ff @(posedge clk) begin
            if (sel_a)      words[wa_addr[BANK_AW-1:0]] <= wa_data;
            else if (sel_b) words[wb_addr[BANK_AW-1:0]] <= wb_data;
        end

        assign bank_ra[b] = words[ra_addr[BANK_AW-1:0]];
        assign bank_rb[b] = words[rb_addr[BANK_AW-1:0]];
    end

    assign ra_data = bank_ra[ra_addr[PTR_W-1]];
    assign rb_data = bank_rb[rb_addr[PTR_W-1]];
endmodule

// File: rtl/sm_fifo_pair.sv
module sm_fifo_pair #(
    parameter int DATA_W     = 32,
    parameter int BANK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_tx_join,
    input  logic              cfg_rx_join,
    input  logic              host_tx_push,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rx_pop,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              ovf_clear,
    output logic              tx_overflow,
    input  logic              sm_tx_pop,
    output logic [DATA_W-1:0] sm_tx_data,
    output logic              sm_tx_stall,
    input  logic              sm_rx_push,
    input  logic [DATA_W-1:0] sm_rx_data,
    output logic              sm_rx_stall,
    output logic [3:0]        tx_level,
    output logic [3:0]        rx_level,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_empty
);
    localparam int PTR_W = $clog2(2 * BANK_DEPTH);
    localparam int LVL_W = PTR_W + 1;
    localparam logic [PTR_W-1:0] HALF_OFS = PTR_W'(BANK_DEPTH);

    logic             flush, split;
    logic [LVL_W-1:0] tx_depth, rx_depth;
    logic             tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [PTR_W-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
    logic [PTR_W-1:0] rx_wa, rx_ra;

    fifo_pair_ctrl #(.BANK_DEPTH(BANK_DEPTH), .LVL_W(LVL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_tx_join(cfg_tx_join), .cfg_rx_join(cfg_rx_join),
        .flush(flush), .split(split), .tx_depth(tx_depth), .rx_depth(rx_depth)
    );

    fifo_pair_queue #(.PTR_W(PTR_W), .LVL_W(LVL_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .depth(tx_depth),
        .push(host_tx_push), .pop(sm_tx_pop),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok),
        .wr_ptr(tx_wp), .rd_ptr(tx_rp),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    fifo_pair_queue #(.PTR_W(PTR_W), .LVL_W(LVL_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .depth(rx_depth),
        .push(sm_rx_push), .pop(host_rx_pop),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
        .wr_ptr(rx_wp), .rd_ptr(rx_rp),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    // In split mode the receive side lives in the upper bank.
    assign rx_wa = split ? (rx_wp | HALF_OFS) : rx_wp;
    assign rx_ra = split ? (rx_rp | HALF_OFS) : rx_rp;

    fifo_pair_store #(.DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH), .PTR_W(PTR_W)) u_store (
        .clk(clk),
        .wa_en(tx_push_ok), .wa_addr(tx_wp), .wa_data(host_tx_data),
        .wb_en(rx_push_ok), .wb_addr(rx_wa), .wb_data(sm_rx_data),
        .ra_addr(tx_rp), .ra_data(sm_tx_data),
        .rb_addr(rx_ra), .rb_data(host_rx_data)
    );

    assign sm_tx_stall = sm_tx_pop && tx_empty;
    assign sm_rx_stall = sm_rx_push && rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     tx_overflow <= 1'b0;
        else if (host_tx_push && tx_full) tx_overflow <= 1'b1;
        else if (ovf_clear)             tx_overflow <= 1'b0;
    end
endmodule

// File: rtl/sm_fifo_pair_chk.sv
module sm_fifo_pair_chk #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             host_tx_push,
    input logic             host_rx_pop,
    input logic             ovf_clear,
    input logic             sm_tx_pop,
    input logic             sm_rx_push,
    input logic [3:0]       tx_level,
    input logic [3:0]       rx_level,
    input logic             tx_full,
    input logic             tx_empty,
    input logic             rx_full,
    input logic             rx_empty,
    input logic             tx_overflow,
    input logic             sm_tx_stall,
    input logic             sm_rx_stall,
    input logic [LVL_W-1:0] tx_depth,
    input logic [LVL_W-1:0] rx_depth
);
    p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= tx_depth) && (rx_level <= rx_depth));

    p_tx_donated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_depth == '0) |-> (tx_empty && tx_full));

    p_rx_donated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_depth == '0) |-> (rx_empty && rx_full));

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (tx_level == '0 && rx_level == '0));

    p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_tx_push && tx_full) |=> tx_overflow);

    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_tx_push && tx_full && !sm_tx_pop && !cfg_we) |=> $stable(tx_level));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overflow && !ovf_clear) |=> tx_overflow);

    p_tx_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_tx_pop && tx_empty && !host_tx_push && !cfg_we) |-> sm_tx_stall ##1 $stable(tx_level));

    p_rx_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_rx_push && rx_full && !host_rx_pop && !cfg_we) |-> sm_rx_stall ##1 $stable(rx_level));

    p_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_depth != '0) |-> (tx_empty == (tx_level == 4'd0)) && (tx_full == (tx_level == 4'(tx_depth))));
endmodule

bind sm_fifo_pair sm_fifo_pair_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .host_tx_push(host_tx_push),
    .host_rx_pop(host_rx_pop), .ovf_clear(ovf_clear), .sm_tx_pop(sm_tx_pop),
    .sm_rx_push(sm_rx_push), .tx_level(tx_level), .rx_level(rx_level),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_overflow(tx_overflow), .sm_tx_stall(sm_tx_stall), .sm_rx_stall(sm_rx_stall),
    .tx_depth(tx_depth), .rx_depth(rx_depth)
);

// File: tb/tb_sm_fifo_pair.sv
module tb_sm_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_tx_join = 0, cfg_rx_join = 0;
    logic        host_tx_push = 0, host_rx_pop = 0, ovf_clear = 0;
    logic        sm_tx_pop = 0, sm_rx_push = 0;
    logic [31:0] host_tx_data = 0, sm_rx_data = 0;
    logic [31:0] host_rx_data, sm_tx_data;
    logic        tx_overflow, sm_tx_stall, sm_rx_stall;
    logic [3:0]  tx_level, rx_level;
    logic        tx_full, tx_empty, rx_full, rx_empty;

    always #5 clk = ~clk;

    sm_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tx_join(cfg_tx_join),
        .cfg_rx_join(cfg_rx_join), .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data), .ovf_clear(ovf_clear),
        .tx_overflow(tx_overflow), .sm_tx_pop(sm_tx_pop), .sm_tx_data(sm_tx_data),
        .sm_tx_stall(sm_tx_stall), .sm_rx_push(sm_rx_push), .sm_rx_data(sm_rx_data),
        .sm_rx_stall(sm_rx_stall), .tx_level(tx_level), .rx_level(rx_level),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model
    logic [31:0] mtx[$];
    logic [31:0] mrx[$];
    int  mmode = 0;
    bit  movf = 0;
    bit  mflushed = 0;

    function automatic int tx_cap(int m);
        return (m == 0) ? 4 : (m == 1) ? 8 : 0;
    endfunction
    function automatic int rx_cap(int m);
        return (m == 0) ? 4 : (m == 2) ? 8 : 0;
    endfunction
    function automatic string mode_tag(int m);
        return (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        string t   = mflushed ? "R6" : mode_tag(mmode);
        string tf  = (tx_cap(mmode) == 0) ? mode_tag(mmode) : "R11";
        string rf  = (rx_cap(mmode) == 0) ? mode_tag(mmode) : "R11";
        int    ntx = mtx.size();
        int    nrx = mrx.size();
        chk(t,  "tx_level", 32'(tx_level), 32'(ntx));
        chk(t,  "rx_level", 32'(rx_level), 32'(nrx));
        chk(tf, "tx_full",  32'(tx_full),  32'(ntx >= tx_cap(mmode)));
        chk(tf, "tx_empty", 32'(tx_empty), 32'(ntx == 0));
        chk(rf, "rx_full",  32'(rx_full),  32'(nrx >= rx_cap(mmode)));
        chk(rf, "rx_empty", 32'(rx_empty), 32'(nrx == 0));
        chk("R7", "tx_overflow", 32'(tx_overflow), 32'(movf));
        chk("R9", "sm_tx_stall", 32'(sm_tx_stall), 32'(sm_tx_pop && ntx == 0));
        chk("R9", "sm_rx_stall", 32'(sm_rx_stall), 32'(sm_rx_push && nrx >= rx_cap(mmode)));
        if (ntx > 0) chk("R10", "sm_tx_data",   sm_tx_data,   mtx[0]);
        if (nrx > 0) chk("R10", "host_rx_data", host_rx_data, mrx[0]);
    endtask

    task automatic cycle(bit cw, bit tj, bit rj, bit hp, bit hpop, bit clr, bit sp, bit spush);
        bit tfull, rfull, tpop_ok, tpush_ok, rpop_ok, rpush_ok;
        @(negedge clk);
        cfg_we = cw; cfg_tx_join = tj; cfg_rx_join = rj;
        host_tx_push = hp; host_rx_pop = hpop; ovf_clear = clr;
        sm_tx_pop = sp; sm_rx_push = spush;
        host_tx_data = $urandom; sm_rx_data = $urandom;
        #1;
        check_outputs();
        tfull = (mtx.size() >= tx_cap(mmode));
        rfull = (mrx.size() >= rx_cap(mmode));
        if (hp && tfull) movf = 1;
        else if (clr)    movf = 0;
        if (cw) begin
            mtx.delete(); mrx.delete();
            mmode = (tj ? 1 : 0) + (rj ? 2 : 0);
            mflushed = 1;
        end else begin
            tpop_ok  = sp && mtx.size() > 0;
            tpush_ok = hp && !tfull;
            rpop_ok  = hpop && mrx.size() > 0;
            rpush_ok = spush && !rfull;
            if (tpop_ok)  void'(mtx.pop_front());
            if (tpush_ok) mtx.push_back(host_tx_data);
            if (rpop_ok)  void'(mrx.pop_front());
            if (rpush_ok) mrx.push_back(sm_rx_data);
            mflushed = 0;
        end
    endtask

    task automatic idle(); cycle(0,0,0,0,0,0,0,0); endtask

    initial begin
        #(10 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "tx_level", 32'(tx_level), 0);
        chk("R1", "rx_level", 32'(rx_level), 0);
        chk("R1", "flags", {28'd0, tx_empty, rx_empty, tx_full, rx_full}, 32'hC);
        chk("R1", "tx_overflow", 32'(tx_overflow), 0);

        // R2 and R7: split mode, five host writes, five machine writes
        repeat (5) cycle(0,0,0,1,0,0,0,1);
        idle();
        chk("R7", "overflow after fifth write", 32'(tx_overflow), 1);
        // R8: overflow and clear in the same cycle keep the flag
        cycle(0,0,0,1,0,1,0,0);
        idle();
        chk("R8", "set wins over clear", 32'(tx_overflow), 1);
        cycle(0,0,0,0,0,1,0,0);
        idle();
        chk("R8", "cleared by strobe", 32'(tx_overflow), 0);
        repeat (5) cycle(0,0,0,0,1,0,1,0);

        // R3: transmit joined, nine writes then nine pops
        cycle(1,1,0,0,0,0,0,0);
        repeat (9) cycle(0,0,0,1,0,1,0,1);
        idle();
        chk("R3", "tx_level joined", 32'(tx_level), 8);
        repeat (9) cycle(0,0,0,0,1,0,1,0);

        // R4: receive joined
        cycle(1,0,1,0,0,0,0,0);
        repeat (9) cycle(0,0,0,1,0,1,0,1);
        idle();
        chk("R4", "rx_level joined", 32'(rx_level), 8);
        // R6: rewrite the same setting with data queued
        cycle(1,0,1,0,0,0,0,0);
        idle();
        chk("R6", "same-value flush", 32'(rx_level), 0);

        // R5: both bits
        cycle(1,1,1,0,0,0,0,0);
        repeat (3) cycle(0,0,0,1,1,1,1,1);
        cycle(1,0,0,0,0,1,0,0);

        // Random traffic in phases of varying pressure
        for (int ph = 0; ph < 12; ph++) begin
            int pp = $urandom_range(20, 90);
            int qp = $urandom_range(20, 90);
            for (int i = 0; i < 400; i++) begin
                bit cw = ($urandom_range(0, 59) == 0);
                cycle(cw, 1'($urandom), 1'($urandom),
                      $urandom_range(0, 99) < pp, $urandom_range(0, 99) < qp,
                      $urandom_range(0, 15) == 0,
                      $urandom_range(0, 99) < qp, $urandom_range(0, 99) < pp);
            end
        end
        idle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule